// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits in front of a memory bus and decides, for every access, whether it may go ahead. It holds eight programmable protection regions. Each region has a power-of-two size, a base aligned to that size, an on/off flag, a three-bit permission code, an execute-never bit, a memory type and a shareable flag. Each access carries an address, a direction, an instruction/data flag and a privilege level. The block finds the region that governs the access, checks the permissions and reports either a grant or a fault, together with the resolved memory attributes.

Overlapping regions are allowed. The highest-numbered enabled region that contains the address always wins. An address that hits no enabled region falls to a background map. Only privileged accesses may use the background map; they get default attributes there. Instruction fetches and data accesses use one common set of regions. A global enable turns checking off, and while it is off every access is granted with default attributes.

Regions are programmed through a one-cycle write port that loads a whole region at once. The response to each access is registered. It appears one clock after the request, together with a copy of the address and the access type.

Top module: `mpr_checker`

## Requirements
- R1: A region write (`rgn_wr`) loads every field of region `rgn_idx` in one clock edge. An access presented in the same cycle as the write is checked against the old contents, and the next access is checked against the new contents.
- R2: A region covers 2^`rgn_size` bytes. `rgn_size` is clamped to the range 5..32. The base address bits below the size are ignored, so an address matches when its bits at and above the size equal those of the base. A size of 32 covers the whole address space.
- R3: When several enabled regions contain the address, the highest-numbered one governs. `rsp_region` reports its index and `rsp_hit` is 1.
- R4: When checking is on and no enabled region contains the address, `rsp_hit` is 0 and `rsp_region` is 0. A privileged access is then granted with default attributes (type normal, not shared). An unprivileged access faults.
- R5: Permission codes: 000 gives no access. 001 gives privileged read/write only. 010 gives privileged read/write and unprivileged read. 011 gives read/write for both levels. 110 and 111 give read only for both levels. 100 and 101 give no access.
- R6: An instruction fetch (`acc_instr`=1) from a region whose execute-never bit is set always faults, even when its permission code allows reads.
- R7: Instruction fetches are checked against the same regions as data, as reads of their level, whatever the value of `acc_write`.
- R8: A faulting access has `rsp_fault`=1 and `rsp_grant`=0. A permitted access has `rsp_grant`=1. Every response carries the registered copy of the request's address, write flag, instruction flag and privilege flag.
- R9: `rsp_mtype` and `rsp_share` report the governing region's type (00 normal, 01 device, 10 strongly-ordered) and shareable flag. A strongly-ordered region is always reported as shared.
- R10: While the global enable (set through `ctl_wr`/`ctl_enable`, cleared by reset) is 0, every access is granted with `rsp_hit`=0, `rsp_region`=0, type normal and not shared, and no fault is ever raised.
- R11: A region whose on-flag is 0 takes part in no match, so lower regions or the background map govern its addresses.
- R12: `rsp_valid` is 1 exactly one cycle after a cycle with `acc_valid`=1, and 0 otherwise. Reset clears all regions, the global enable and the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Load the global enable |
| ctl_enable | input | 1 | Global enable value to load |
| rgn_wr | input | 1 | Load one region |
| rgn_idx | input | 3 | Index of the region to load |
| rgn_base | input | 32 | Region base address |
| rgn_size | input | 6 | Log2 of the region size in bytes |
| rgn_perm | input | 3 | Permission code |
| rgn_xn | input | 1 | Execute-never bit |
| rgn_mtype | input | 2 | Memory type |
| rgn_share | input | 1 | Shareable flag |
| rgn_on | input | 1 | Region on-flag |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_instr | input | 1 | 1 for instruction fetch |
| acc_priv | input | 1 | 1 for privileged access |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access may be forwarded |
| rsp_fault | output | 1 | Memory-management fault |
| rsp_hit | output | 1 | A region governed (0: background or checking off) |
| rsp_region | output | 3 | Governing region index |
| rsp_mtype | output | 2 | Resolved memory type |
| rsp_share | output | 1 | Resolved shareable flag |
| rsp_addr | output | 32 | Registered request address |
| rsp_write | output | 1 | Registered write flag |
| rsp_instr | output | 1 | Registered instruction flag |
| rsp_priv | output | 1 | Registered privilege flag |

## Verification
The bench uses the package defaults: eight regions, a 32-bit address and a 32-byte minimum region. Eight regions let it stack a small region inside a larger lower-numbered one and place a whole-space region under everything. This exercises both the priority order and the background fallback. The 32-bit address makes the 4 GB region and the 32-byte minimum reachable, so the bench checks the size clamp and the alignment masking at both ends. The full permission table is walked for every code, both privilege levels and both directions.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
    localparam int ADDR_W = 32;
    localparam int NREG   = 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int SZ_W   = 6;
    localparam int MIN_SZ = 5;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'b00,
        MT_DEVICE = 2'b01,
        MT_STRONG = 2'b10,
        MT_RSVD   = 2'b11
    } mtype_e;

    typedef enum logic [2:0] {
        AP_NONE    = 3'b000,
        AP_PRIV_RW = 3'b001,
        AP_USER_RO = 3'b010,
        AP_FULL    = 3'b011,
        AP_RSV4    = 3'b100,
        AP_RSV5    = 3'b101,
        AP_RO_A    = 3'b110,
        AP_RO_B    = 3'b111
    } perm_e;

    typedef struct packed {
        perm_e  perm;
        logic   xn;
        mtype_e mtype;
        logic   share;
    } attr_t;

    typedef struct packed {
        logic              on;
        logic [ADDR_W-1:0] base;
        logic [SZ_W-1:0]   size;
        attr_t             attr;
    } region_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
        attr_t            attr;
    } resolve_t;

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] s);
        if (int'(s) < MIN_SZ) return SZ_W'(MIN_SZ);
        if (int'(s) > ADDR_W) return SZ_W'(ADDR_W);
        return s;
    endfunction

    // Ones in every bit position at or above the size exponent.
    function automatic logic [ADDR_W-1:0] size_mask(input logic [SZ_W-1:0] s);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < ADDR_W; b++)
            if (b >= int'(s)) m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic perm_allows(input perm_e p, input logic priv, input logic wr);
        case (p)
            AP_PRIV_RW:       return priv;
            AP_USER_RO:       return priv | ~wr;
            AP_FULL:          return 1'b1;
            AP_RO_A, AP_RO_B: return ~wr;
            default:          return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mpr_region_bank.sv
module mpr_region_bank
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = NREG
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [IDX_W-1:0]       wr_idx,
    input  region_t                wr_data,
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_REGIONS-1:0] match,
    output attr_t                  attrs [NUM_REGIONS]
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        region_t r_q;

        always_ff @(posedge clk) begin
            if (rst)
                r_q <= '0;
            else if (wr && wr_idx == IDX_W'(g))
                r_q <= wr_data;
        end

        assign match[g] = r_q.on && ((addr & size_mask(r_q.size)) == r_q.base);
        assign attrs[g] = r_q.attr;
    end
endmodule

// File: rtl/mpr_resolver.sv
module mpr_resolver
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = NREG
) (
    input  logic [NUM_REGIONS-1:0] match,
    input  attr_t                  attrs [NUM_REGIONS],
    output resolve_t               res
);
    // Ascending scan: the last (highest) match overwrites earlier ones.
    always_comb begin
        res = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (match[i]) begin
                res.hit  = 1'b1;
                res.idx  = IDX_W'(i);
                res.attr = attrs[i];
            end
        end
    end
endmodule

// File: rtl/mpr_perm_check.sv
module mpr_perm_check
    import mpr_pkg::*;
(
    input  logic   chk_en,
    input  logic   hit,
    input  attr_t  attr,
    input  logic   is_write,
    input  logic   is_instr,
    input  logic   is_priv,
    output logic   fault,
    output mtype_e mtype,
    output logic   share
);
    logic eff_write;

    always_comb begin
        eff_write = is_write & ~is_instr;
        if (!chk_en)
            fault = 1'b0;
        else if (!hit)
            fault = ~is_priv;
        else
            fault = ~perm_allows(attr.perm, is_priv, eff_write) | (is_instr & attr.xn);

        if (chk_en && hit) begin
            mtype = attr.mtype;
            share = attr.share | (attr.mtype == MT_STRONG);
        end else begin
            mtype = MT_NORMAL;
            share = 1'b0;
        end
    end
endmodule

// File: rtl/mpr_checker.sv
module mpr_checker
    import mpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_enable,
    input  logic              rgn_wr,
    input  logic [IDX_W-1:0]  rgn_idx,
    input  logic [ADDR_W-1:0] rgn_base,
    input  logic [SZ_W-1:0]   rgn_size,
    input  logic [2:0]        rgn_perm,
    input  logic              rgn_xn,
    input  logic [1:0]        rgn_mtype,
    input  logic              rgn_share,
    input  logic              rgn_on,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_instr,
    input  logic              acc_priv,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_region,
    output logic [1:0]        rsp_mtype,
    output logic              rsp_share,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic              rsp_instr,
    output logic              rsp_priv
);
    logic              glob_en_q;
    region_t           wr_rgn;
    logic [SZ_W-1:0]   wr_size;
    logic [NREG-1:0]   match;
    attr_t             attrs [NREG];
    resolve_t          res;
    logic              fault_c;
    mtype_e            mtype_c;
    logic              share_c;

    always_ff @(posedge clk) begin
        if (rst)
            glob_en_q <= 1'b0;
        else if (ctl_wr)
            glob_en_q <= ctl_enable;
    end

    // Normalise the write so the stored base is already aligned.
    always_comb begin
        wr_size           = clamp_size(rgn_size);
        wr_rgn.on         = rgn_on;
        wr_rgn.size       = wr_size;
        wr_rgn.base       = rgn_base & size_mask(wr_size);
        wr_rgn.attr.perm  = perm_e'(rgn_perm);
        wr_rgn.attr.xn    = rgn_xn;
        wr_rgn.attr.mtype = mtype_e'(rgn_mtype);
        wr_rgn.attr.share = rgn_share;
    end

    mpr_region_bank #(.NUM_REGIONS(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr      (rgn_wr),
        .wr_idx  (rgn_idx),
        .wr_data (wr_rgn),
        .addr    (acc_addr),
        .match   (match),
        .attrs   (attrs)
    );

    mpr_resolver #(.NUM_REGIONS(NREG)) u_res (
        .match (match),
        .attrs (attrs),
        .res   (res)
    );

    mpr_perm_check u_perm (
        .chk_en   (glob_en_q),
        .hit      (res.hit),
        .attr     (res.attr),
        .is_write (acc_write),
        .is_instr (acc_instr),
        .is_priv  (acc_priv),
        .fault    (fault_c),
        .mtype    (mtype_c),
        .share    (share_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_region <= '0;
            rsp_mtype  <= MT_NORMAL;
            rsp_share  <= 1'b0;
            rsp_addr   <= '0;
            rsp_write  <= 1'b0;
            rsp_instr  <= 1'b0;
            rsp_priv   <= 1'b0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_grant <= acc_valid & ~fault_c;
            rsp_fault <= acc_valid & fault_c;
            if (acc_valid) begin
                rsp_hit    <= glob_en_q & res.hit;
                rsp_region <= (glob_en_q && res.hit) ? res.idx : '0;
                rsp_mtype  <= mtype_c;
                rsp_share  <= share_c;
                rsp_addr   <= acc_addr;
                rsp_write  <= acc_write;
                rsp_instr  <= acc_instr;
                rsp_priv   <= acc_priv;
            end
        end
    end
endmodule

// File: rtl/mpr_checker_sva.sv
module mpr_checker_sva (
    input logic        clk,
    input logic        rst,
    input logic        glob_en,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        rsp_valid,
    input logic        rsp_grant,
    input logic        rsp_fault,
    input logic        rsp_hit,
    input logic        rsp_priv,
    input logic [1:0]  rsp_mtype,
    input logic        rsp_share,
    input logic [31:0] rsp_addr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid && rsp_addr == $past(acc_addr)); // R12
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid); // R12
    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid && !rsp_grant); // R8
    AST_STRONG_SHARED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_mtype == 2'b10 |-> rsp_share); // R9
    AST_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !$past(glob_en) |-> !rsp_fault && !rsp_hit); // R10
    AST_USER_MISS_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(glob_en) && !rsp_hit && !rsp_priv |-> rsp_fault); // R4
endmodule

bind mpr_checker mpr_checker_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .glob_en   (glob_en_q),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_fault (rsp_fault),
    .rsp_hit   (rsp_hit),
    .rsp_priv  (rsp_priv),
    .rsp_mtype (rsp_mtype),
    .rsp_share (rsp_share),
    .rsp_addr  (rsp_addr)
);

// File: tb/mpr_checker_bench.sv
module mpr_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0, ctl_enable = 1'b0;
    logic        rgn_wr = 1'b0;
    logic [2:0]  rgn_idx = '0;
    logic [31:0] rgn_base = '0;
    logic [5:0]  rgn_size = '0;
    logic [2:0]  rgn_perm = '0;
    logic        rgn_xn = 1'b0, rgn_share = 1'b0, rgn_on = 1'b0;
    logic [1:0]  rgn_mtype = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0, acc_instr = 1'b0, acc_priv = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_fault, rsp_hit, rsp_share;
    logic [2:0]  rsp_region;
    logic [1:0]  rsp_mtype;
    logic [31:0] rsp_addr;
    logic        rsp_write, rsp_instr, rsp_priv;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mpr_checker u_mpr_checker (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_enable(ctl_enable),
        .rgn_wr(rgn_wr), .rgn_idx(rgn_idx), .rgn_base(rgn_base), .rgn_size(rgn_size),
        .rgn_perm(rgn_perm), .rgn_xn(rgn_xn), .rgn_mtype(rgn_mtype), .rgn_share(rgn_share),
        .rgn_on(rgn_on), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_instr(acc_instr), .acc_priv(acc_priv), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .rsp_hit(rsp_hit), .rsp_region(rsp_region), .rsp_mtype(rsp_mtype),
        .rsp_share(rsp_share), .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_instr(rsp_instr),
        .rsp_priv(rsp_priv)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic perm_ok(input logic [2:0] p, input logic priv, input logic wr);
        case (p)
            3'b001: return priv;
            3'b010: return priv | ~wr;
            3'b011: return 1'b1;
            3'b110, 3'b111: return ~wr;
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_enable(input logic en);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_enable = en;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic drive_rgn(input logic [2:0] idx, input logic [31:0] base, input logic [5:0] sz,
                             input logic [2:0] perm, input logic xn, input logic [1:0] mt,
                             input logic sh, input logic on);
        rgn_wr = 1'b1; rgn_idx = idx; rgn_base = base; rgn_size = sz;
        rgn_perm = perm; rgn_xn = xn; rgn_mtype = mt; rgn_share = sh; rgn_on = on;
    endtask

    task automatic prog(input logic [2:0] idx, input logic [31:0] base, input logic [5:0] sz,
                        input logic [2:0] perm, input logic xn, input logic [1:0] mt,
                        input logic sh, input logic on);
        @(negedge clk);
        drive_rgn(idx, base, sz, perm, xn, mt, sh, on);
        @(posedge clk);
        @(negedge clk);
        rgn_wr = 1'b0;
    endtask

    // Expected vector: {valid, fault, grant, hit, region[2:0], mtype[1:0], share}
    task automatic access(input string req, input logic [31:0] a, input logic wr, input logic ins,
                          input logic pv, input logic f, input logic h, input logic [2:0] idx,
                          input logic [1:0] mt, input logic sh);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_instr = ins; acc_priv = pv;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; rgn_wr = 1'b0;
        check(req, {rsp_valid, rsp_fault, rsp_grant, rsp_hit, rsp_region, rsp_mtype, rsp_share},
                   {1'b1, f, ~f, h, idx, mt, sh});
        check({req, " echo"}, {rsp_addr, rsp_write, rsp_instr, rsp_priv}, {a, wr, ins, pv});
    endtask

    task automatic t_reset();
        check("R12 reset", {rsp_valid, rsp_fault, rsp_grant}, 3'b000);
    endtask

    task automatic t_disabled();
        access("R10 off user write", 32'h0000_1234, 1, 0, 0, 0, 0, 3'd0, 2'b00, 0);
        access("R10 off user fetch", 32'hF000_0000, 0, 1, 0, 0, 0, 3'd0, 2'b00, 0);
    endtask

    task automatic t_basic_and_background();
        set_enable(1);
        prog(3'd0, 32'h2000_0000, 6'd16, 3'b011, 0, 2'b01, 0, 1);
        access("R2 in region 0", 32'h2000_FFFC, 0, 0, 0, 0, 1, 3'd0, 2'b01, 0);
        access("R4 user miss faults", 32'h2001_0000, 0, 0, 0, 1, 0, 3'd0, 2'b00, 0);
        access("R4 priv miss background", 32'h2001_0000, 1, 0, 1, 0, 0, 3'd0, 2'b00, 0);
    endtask

    task automatic t_overlap();
        prog(3'd5, 32'h2000_1000, 6'd12, 3'b000, 0, 2'b10, 0, 1);
        access("R3 higher region wins", 32'h2000_1004, 0, 0, 1, 1, 1, 3'd5, 2'b10, 1);
        access("R3 outside inner", 32'h2000_2000, 0, 0, 0, 0, 1, 3'd0, 2'b01, 0);
        prog(3'd5, 32'h2000_1000, 6'd12, 3'b011, 0, 2'b10, 0, 1);
        access("R9 strongly-ordered shared", 32'h2000_1FFC, 1, 0, 0, 0, 1, 3'd5, 2'b10, 1);
        prog(3'd5, 32'h2000_1000, 6'd12, 3'b011, 0, 2'b10, 0, 0);
        access("R11 disabled region ignored", 32'h2000_1004, 0, 0, 0, 0, 1, 3'd0, 2'b01, 0);
    endtask

    task automatic t_perm_table();
        for (int p = 0; p < 8; p++) begin
            prog(3'd7, 32'h4000_0000, 6'd20, 3'(p), 0, 2'b00, 1, 1);
            for (int k = 0; k < 4; k++) begin
                logic pv, wr, ok;
                pv = k[1]; wr = k[0];
                ok = perm_ok(3'(p), pv, wr);
                access($sformatf("R5 code %0d priv %0d write %0d", p, pv, wr),
                       32'h4000_0100, wr, 0, pv, ~ok, 1, 3'd7, 2'b00, 1);
            end
        end
    endtask

    task automatic t_exec();
        prog(3'd7, 32'h4000_0000, 6'd20, 3'b011, 1, 2'b00, 0, 1);
        access("R6 xn fetch faults", 32'h4000_0200, 0, 1, 1, 1, 1, 3'd7, 2'b00, 0);
        access("R6 xn data read ok", 32'h4000_0200, 0, 0, 0, 0, 1, 3'd7, 2'b00, 0);
        prog(3'd7, 32'h4000_0000, 6'd20, 3'b110, 0, 2'b00, 0, 1);
        access("R7 fetch as read on RO", 32'h4000_0200, 1, 1, 0, 0, 1, 3'd7, 2'b00, 0);
        prog(3'd7, 32'h4000_0000, 6'd20, 3'b000, 0, 2'b00, 0, 1);
        access("R7 fetch on no-access", 32'h4000_0200, 0, 1, 1, 1, 1, 3'd7, 2'b00, 0);
    endtask

    task automatic t_sizes();
        prog(3'd2, 32'h6000_0013, 6'd3, 3'b011, 0, 2'b00, 0, 1);
        access("R2 clamp low top byte", 32'h6000_001F, 0, 0, 0, 0, 1, 3'd2, 2'b00, 0);
        access("R2 clamp low next byte", 32'h6000_0020, 0, 0, 0, 1, 0, 3'd0, 2'b00, 0);
        prog(3'd1, 32'hFFFF_FFFF, 6'd40, 3'b011, 0, 2'b01, 0, 1);
        access("R2 whole space", 32'h9000_0000, 0, 0, 0, 0, 1, 3'd1, 2'b01, 0);
        access("R3 whole space under 2", 32'h6000_0004, 0, 0, 0, 0, 1, 3'd2, 2'b00, 0);
    endtask

    task automatic t_atomic();
        @(negedge clk);
        drive_rgn(3'd6, 32'h7000_0000, 6'd16, 3'b000, 0, 2'b01, 0, 1);
        acc_valid = 1'b1; acc_addr = 32'h7000_0040; acc_write = 0; acc_instr = 0; acc_priv = 1;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; rgn_wr = 1'b0;
        check("R1 same-cycle sees old", {rsp_fault, rsp_hit, rsp_region}, {1'b0, 1'b1, 3'd1});
        access("R1 next access sees new", 32'h7000_0040, 0, 0, 1, 1, 1, 3'd6, 2'b01, 0);
    endtask

    task automatic t_off_again();
        set_enable(0);
        access("R10 off ignores regions", 32'h7000_0040, 1, 1, 0, 0, 0, 3'd0, 2'b00, 0);
        @(negedge clk);
        check("R12 idle no response", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_basic_and_background();
        t_overlap();
        t_perm_table();
        t_exec();
        t_sizes();
        t_atomic();
        t_off_again();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule